// File: doc/BRIEF.md
# Binary to residue forward converter

This block turns an unsigned binary word of 3n bits into its residues for the three moduli 2^n, 2^n-1 and 2^n+1. It is the entry stage of a residue-number datapath: each residue then feeds its own modular channel. With the default n = 4 the word is 12 bits wide and the moduli are 16, 15 and 17.

The word is cut into three n-bit fields: hi (top), mid and lo (bottom), so the value is hi·2^(2n) + mid·2^n + lo. No divider is used. The 2^n residue is the low field. The 2^n-1 residue folds the three fields through a carry-save row and an adder whose carry-out is fed back into its carry-in. The 2^n+1 residue forms the signed sum hi - mid + lo and corrects it by one modulus, up or down, depending on its sign and size. All three results are registered. They appear one cycle after a strobed input, together with a valid flag.

Top module: `res_fwd_conv`

## Requirements
- R1: One cycle after a cycle with `in_valid` high, `res_p2` equals the low N bits of the `in_word` sampled in that cycle, which is `in_word` mod 2^N.
- R2: One cycle after a strobed input, `res_m1` equals `in_word` mod (2^N-1). It is never all ones: an end-around sum of 2^N-1 is reported as 0.
- R3: One cycle after a strobed input, `res_p1` (N+1 bits) equals `in_word` mod (2^N+1). The value 2^N is a legal result.
- R4: `out_valid` equals the value `in_valid` had on the previous clock edge.
- R5: In a cycle with `in_valid` low, the three residue outputs keep their values regardless of `in_word`.
- R6: While `rst_n` is low at a clock edge, all outputs are 0 after that edge.
- R7: With N=4, the input 0x94C (2380) gives `res_p2`=12, `res_m1`=10 and `res_p1`=0.
- R8: `res_p1` never exceeds 2^N, and `res_m1` never exceeds 2^N-2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word strobe |
| in_word | input | 3N | Unsigned binary input word |
| out_valid | output | 1 | Residues updated on the previous edge |
| res_p2 | output | N | Residue modulo 2^N |
| res_m1 | output | N | Residue modulo 2^N-1 |
| res_p1 | output | N+1 | Residue modulo 2^N+1 |

## Verification
On every cycle the assertions check the valid timing, the holding of the residues when no strobe arrives, the reset values, the low-field pass-through and the legal ranges of both folded residues, including that the all-ones code never leaves the 2^N-1 path. Whether the folded residues are arithmetically correct is shown only by the bench. It compares them against direct division on random words and on directed corner cases: all zeros, all ones, the known 2380 vector, words whose 2^N+1 residue is 2^N, and words whose field sum is an exact multiple of 2^N-1.

// File: rtl/fwdres_pkg.sv
// Package: shared constants for the forward residue converter.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package fwdres_pkg;
    // Default field width; moduli 16, 15 and 17 follow from it.
    localparam int unsigned DEF_N = 4;
    // Extra bits needed above N for the signed hi - mid + lo sum.
    localparam int unsigned SGN_EXTRA = 3;
endpackage

// File: rtl/res_mod_m1.sv
// Module: res_mod_m1
// Computes (hi + mid + lo) mod (2^N - 1) without division.
// A row of full adders reduces three fields to sum and carry vectors.
// The carry vector is rotated left by one, which is its weight modulo
// 2^N - 1. An end-around-carry adder then folds the two vectors. An all-ones
// result (the second zero code) is mapped to 0.
// Assumes: N >= 2, purely combinational.
module res_mod_m1 #(
    parameter int unsigned N = fwdres_pkg::DEF_N
) (
    input  logic [N-1:0] hi,
    input  logic [N-1:0] mid,
    input  logic [N-1:0] lo,
    output logic [N-1:0] res
);
    localparam logic [N-1:0] ALL_ONES = {N{1'b1}};

    logic [N-1:0] sum_v;
    logic [N-1:0] maj_v;
    logic [N-1:0] car_rot;
    logic [N:0]   first_add;
    logic [N-1:0] folded;

    // Carry-save row: one full adder cell per bit.
    for (genvar i = 0; i < N; i++) begin : g_csa
        assign sum_v[i] = hi[i] ^ mid[i] ^ lo[i];
        assign maj_v[i] = (hi[i] & mid[i]) | (hi[i] & lo[i]) | (mid[i] & lo[i]);
    end

    // The carry out of bit N-1 has weight 2^N, which is 1 modulo 2^N-1.
    assign car_rot = {maj_v[N-2:0], maj_v[N-1]};

    // End-around-carry addition of the sum and rotated carry vectors.
    always_comb begin
        first_add = {1'b0, sum_v} + {1'b0, car_rot};
        folded    = first_add[N-1:0] + {{(N-1){1'b0}}, first_add[N]};
    end

    // Map the all-ones code to zero so the result stays in 0 .. 2^N-2.
    always_comb begin
        res = (folded == ALL_ONES) ? '0 : folded;
    end
endmodule

// File: rtl/res_mod_p1.sv
// Module: res_mod_p1
// Computes (hi - mid + lo) mod (2^N + 1) without division.
// The signed sum spans -(2^N-1) .. 2*(2^N-1). It is corrected once:
// add the modulus when it is negative, subtract it when it is at or above
// the modulus. The result is N+1 bits, since 2^N is a legal residue.
// Assumes: N >= 2, purely combinational.
module res_mod_p1 #(
    parameter int unsigned N = fwdres_pkg::DEF_N
) (
    input  logic [N-1:0] hi,
    input  logic [N-1:0] mid,
    input  logic [N-1:0] lo,
    output logic [N:0]   res
);
    localparam int unsigned W = N + fwdres_pkg::SGN_EXTRA;
    localparam logic [W-1:0] MODV = W'((1 << N) + 1);
    localparam logic [W-1:0] PADZ = '0;

    logic [W-1:0] ext_hi;
    logic [W-1:0] ext_mid_n;
    logic [W-1:0] ext_lo;
    logic [W-1:0] raw;
    logic [W-1:0] fixed;

    // Widen the fields, with the two's complement of the middle one.
    always_comb begin
        ext_hi    = {PADZ[W-1:N], hi};
        ext_lo    = {PADZ[W-1:N], lo};
        ext_mid_n = ~{PADZ[W-1:N], mid} + W'(1);
    end

    // Alternating-sign sum in W-bit two's complement.
    always_comb begin
        raw = ext_hi + ext_lo + ext_mid_n;
    end

    // Sign and size based single correction step.
    always_comb begin
        if (raw[W-1]) begin
            fixed = raw + MODV;
        end else if (raw >= MODV) begin
            fixed = raw - MODV;
        end else begin
            fixed = raw;
        end
    end

    // Keep the N+1 magnitude bits of the corrected value.
    always_comb begin
        res = fixed[N:0];
    end
endmodule

// File: rtl/res_fwd_conv.sv
// Module: res_fwd_conv (top)
// Splits a 3N-bit word into hi, mid and lo fields. It derives the residues
// modulo 2^N, 2^N-1 and 2^N+1 and registers them with one cycle of latency.
// Residues load only on a strobe. The valid flag follows the strobe.
// Assumes: unsigned input, synchronous active-low reset, N >= 2.
module res_fwd_conv #(
    parameter int unsigned N = fwdres_pkg::DEF_N
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [3*N-1:0] in_word,
    output logic           out_valid,
    output logic [N-1:0]   res_p2,
    output logic [N-1:0]   res_m1,
    output logic [N:0]     res_p1
);
    logic [N-1:0] f_hi;
    logic [N-1:0] f_mid;
    logic [N-1:0] f_lo;
    logic [N-1:0] nxt_m1;
    logic [N:0]   nxt_p1;

    // Field split of the input word.
    always_comb begin
        f_hi  = in_word[3*N-1:2*N];
        f_mid = in_word[2*N-1:N];
        f_lo  = in_word[N-1:0];
    end

    res_mod_m1 #(.N(N)) u_m1 (
        .hi  (f_hi),
        .mid (f_mid),
        .lo  (f_lo),
        .res (nxt_m1)
    );

    res_mod_p1 #(.N(N)) u_p1 (
        .hi  (f_hi),
        .mid (f_mid),
        .lo  (f_lo),
        .res (nxt_p1)
    );

    // Output register: load residues on a strobe, track the strobe as valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            res_p2    <= '0;
            res_m1    <= '0;
            res_p1    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_p2 <= f_lo;
                res_m1 <= nxt_m1;
                res_p1 <= nxt_p1;
            end
        end
    end
endmodule

// File: rtl/res_fwd_conv_chk.sv
// Module: res_fwd_conv_chk
// Cycle checks on the converter ports, attached to every instance by bind.
// Assumes: synchronous active-low reset on rst_n.
module res_fwd_conv_chk #(
    parameter int unsigned N = fwdres_pkg::DEF_N
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [3*N-1:0] in_word,
    input logic           out_valid,
    input logic [N-1:0]   res_p2,
    input logic [N-1:0]   res_m1,
    input logic [N:0]     res_p1
);
    localparam logic [N:0]   P1_MAX = {1'b1, {N{1'b0}}};
    localparam logic [N-1:0] M1_BAD = {N{1'b1}};

    // R1: low field passes through after a strobe.
    p_low_field_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_p2 == $past(in_word[N-1:0]));

    // R4: valid tracks the strobe by one cycle.
    p_valid_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    // R5: residues hold without a strobe.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(res_p2) && $stable(res_m1) && $stable(res_p1)));

    // R6: reset clears every output.
    p_reset_r6: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && res_p2 == '0 && res_m1 == '0 && res_p1 == '0));

    // R8: legal range of the 2^N+1 residue.
    p_range_p1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_p1 <= P1_MAX);

    // R2: the all-ones code never reaches the 2^N-1 output.
    p_no_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_m1 != M1_BAD);
endmodule

bind res_fwd_conv res_fwd_conv_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .out_valid (out_valid),
    .res_p2    (res_p2),
    .res_m1    (res_m1),
    .res_p1    (res_p1)
);

// File: tb/res_fwd_conv_tb.sv
// Bench for res_fwd_conv: directed corners plus seeded random words,
// checked against residues computed by direct division.
module res_fwd_conv_tb;
    localparam int unsigned N = 4;
    localparam int unsigned W = 3 * N;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [W-1:0]   in_word = '0;
    logic           out_valid;
    logic [N-1:0]   res_p2;
    logic [N-1:0]   res_m1;
    logic [N:0]     res_p1;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    res_fwd_conv #(.N(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .res_p2(res_p2), .res_m1(res_m1), .res_p1(res_p1)
    );

    function automatic int exp_mod(int x, int m);
        return x % m;
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present a word at the falling edge; sample just after the next rise.
    task automatic apply(int x, bit v);
        @(negedge clk);
        in_word  = W'(x);
        in_valid = v;
        @(posedge clk);
        #1;
    endtask

    task automatic conv_check(int x);
        apply(x, 1'b1);
        check("R4", int'(out_valid), 1);
        check("R1", int'(res_p2), exp_mod(x, 1 << N));
        check("R2", int'(res_m1), exp_mod(x, (1 << N) - 1));
        check("R3", int'(res_p1), exp_mod(x, (1 << N) + 1));
        check("R8", int'(res_p1 <= (1 << N)), 1);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int prev;
        process::self().srandom(32'd1234);
        repeat (3) @(posedge clk);
        #1;
        check("R6", int'(out_valid), 0);
        check("R6", int'(res_p2), 0);
        check("R6", int'(res_m1), 0);
        check("R6", int'(res_p1), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: known vector 0x94C.
        apply(12'h94C, 1'b1);
        check("R7", int'(res_p2), 12);
        check("R7", int'(res_m1), 10);
        check("R7", int'(res_p1), 0);

        // Directed corners: zero, all ones, residue 2^N, exact multiple of 15.
        conv_check(0);
        conv_check((1 << W) - 1);
        conv_check(16);
        conv_check(33);
        conv_check(15);
        conv_check(12'hFF0);
        conv_check(12'h0F0);
        conv_check(12'hF0F);

        // R5: a word without a strobe leaves the residues alone.
        prev = 12'h123;
        conv_check(prev);
        apply(12'hABC, 1'b0);
        check("R4", int'(out_valid), 0);
        check("R5", int'(res_p2), exp_mod(prev, 1 << N));
        check("R5", int'(res_m1), exp_mod(prev, (1 << N) - 1));
        check("R5", int'(res_p1), exp_mod(prev, (1 << N) + 1));

        // Random words, some with the strobe low.
        for (int i = 0; i < 400; i++) begin
            int x;
            x = int'($urandom() % (1 << W));
            if (($urandom() % 5) == 0) begin
                apply(x, 1'b0);
                check("R5", int'(res_p2), exp_mod(prev, 1 << N));
                check("R5", int'(res_p1), exp_mod(prev, (1 << N) + 1));
            end else begin
                conv_check(x);
                prev = x;
            end
        end

        // R6: reset in mid-run clears outputs.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R6", int'(out_valid), 0);
        check("R6", int'(res_m1), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule